// File: doc/BRIEF.md
# Streaming SDRAM Superstate Scheduler

This block sequences commands for a single-data-rate SDRAM that serves as a video frame buffer. It does no random access and no arbitration. Instead it runs a fixed 21-cycle "superstate" over and over. Each superstate is one of three kinds: write, read or idle.

- A write superstate moves 16 words from a streaming write FIFO into the memory.
- A read superstate moves 16 words from the memory into a streaming read FIFO.
- Either kind works through all four banks. Each bank gets its own row activation, a burst of four, and a precharge.
- The activations are overlapped, so one bank opens while the previous bank is still bursting. The data bus is therefore busy for 16 consecutive cycles.

The write stream and the read stream each keep their own row/column pointer. Each pointer moves by one four-column step at the end of every superstate of its own kind. When both streams can be served, the block alternates between them. Because the frame buffer is scanned continuously, the streaming activations keep the array refreshed. No refresh command is issued once the power-up sequence has finished.

The design targets a 100 MHz memory clock, with tRCD = 2 and CAS latency = 2.

Command encoding on `{ras_n, cas_n, we_n}`:

| Command | Code |
|---|---|
| NOP | 111 |
| ACTIVE | 011 |
| READ | 101 |
| WRITE | 100 |
| PRECHARGE | 010 |
| AUTO REFRESH | 001 |
| MODE SET | 000 |

Chip select is held low at all times.

Top module: `sdram_stream_sched`

## Requirements
- R1: After reset the command bus shows NOP, `wr_pop`, `sd_dq_oe` and `rd_valid` are 0, and the power-up sequence runs with cycle 0 as the first cycle after reset release. The steps are:
  - NOP through cycle INIT_WAIT-1.
  - PRECHARGE with address bit 10 set (all banks) at cycle INIT_WAIT.
  - AUTO REFRESH at INIT_WAIT+TRP.
  - AUTO REFRESH again at INIT_WAIT+TRP+TRFC.
  - MODE SET at INIT_WAIT+TRP+2*TRFC, with bank 0 and address 0x022 (burst length 4, sequential, CAS latency 2).
  - NOP during all other cycles of the sequence.
- R2: Superstates start every 21 cycles. The first starts TMRD cycles after the mode set. In a read or write superstate, slot s (0..20) carries these commands for bank b:
  - ACTIVE to bank b at slot 4b.
  - READ or WRITE (address bit 10 = 0) to bank b at slot 4b+2.
  - PRECHARGE to bank b (address bit 10 = 0) at slot 4b+7.
  - NOP in every other slot.
- R3: A write superstate asserts `wr_pop` and `sd_dq_oe` in slots 2..17, which is exactly 16 cycles. In those cycles `sd_dq_out` equals `wr_data`.
- R4: A read superstate takes in `sd_dq_in` in slots 4..19 and presents each word on `rd_data` with `rd_valid` one cycle later, in slots 5..20. No write data is driven during a read superstate.
- R5: The kind of each superstate is chosen from `wr_level` and `rd_free` as they stand in the cycle before it starts:
  - write needs `wr_level` ≥ 16;
  - read needs `rd_free` ≥ 16;
  - if neither holds, the superstate is idle: NOP for all 21 cycles.
- R6: When both streams are eligible, the block serves the stream not served by the most recent non-idle superstate. Write is preferred first after power-up.
- R7: ACTIVE carries the current stream's row and READ/WRITE carries its column, the same values for all four banks. The write and read pointers each start at row 0, column 0. Each pointer advances its column by 4 after a superstate of its own kind. When the column wraps to 0, its row advances by one.
- R8: The read stream returns the words of the write stream in the same order.
- R9: ACTIVE goes only to a closed bank, and READ/WRITE only to an open bank. All banks are closed at every superstate start. After the power-up sequence, no AUTO REFRESH or MODE SET is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_level | input | FILL_W | Words held in the write FIFO |
| wr_data | input | DQ_W | Head word of the write FIFO (show-ahead) |
| wr_pop | output | 1 | Take the head word from the write FIFO |
| rd_free | input | FILL_W | Free entries in the read FIFO |
| rd_data | output | DQ_W | Word pushed to the read FIFO |
| rd_valid | output | 1 | Push strobe for `rd_data` |
| sd_cs_n | output | 1 | Chip select, held low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Row, column or mode address |
| sd_dq_out | output | DQ_W | Write data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for `sd_dq_out` |
| sd_dq_in | input | DQ_W | Read data from the memory |

## Verification
The eligibility assertions and the pop-count assertion assume the FIFO levels are honest. `wr_level` must truly count the words behind `wr_data`, and a popped word must never leave the write FIFO empty before the 16th pop. The stimulus meets this by deriving `wr_level` and `wr_data` from the bench's own queue, and by refreshing both away from the clock edge. Read-data correctness depends on the memory model answering two cycles after each READ from the row opened by the matching ACTIVE. The stimulus allows a read superstate only after enough words have been written, and it lowers `rd_free` once the written data has all been read.

// File: rtl/sdss_pkg.sv
package sdss_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmd_t;

  typedef enum logic [1:0] {
    SS_IDLE  = 2'd0,
    SS_WRITE = 2'd1,
    SS_READ  = 2'd2
  } ss_t;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ACT  = 2'd1,
    K_RW   = 2'd2,
    K_PRE  = 2'd3
  } kind_t;

  localparam int SLOTS      = 21;
  localparam int BURST      = 4;
  localparam int BANKS      = 4;
  localparam int SS_WORDS   = BURST * BANKS;
  localparam int SLOT_W     = 5;
  localparam int LAST_SLOT  = SLOTS - 1;

  // Which step of the per-bank pattern falls on a slot.
  function automatic kind_t slot_kind(input logic [SLOT_W-1:0] s);
    if (s < 5'd16 && s[1:0] == 2'd0)                    return K_ACT;
    if (s < 5'd16 && s[1:0] == 2'd2)                    return K_RW;
    if (s >= 5'd7 && s <= 5'd19 && s[1:0] == 2'd3)      return K_PRE;
    return K_NONE;
  endfunction

  function automatic logic [1:0] slot_bank(input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] t;
    t = (slot_kind(s) == K_PRE) ? s - 5'd7 : s;
    return t[3:2];
  endfunction

  function automatic logic write_beat(input logic [SLOT_W-1:0] s);
    return (s >= 5'd2) && (s <= 5'd17);
  endfunction

  function automatic logic read_capture(input logic [SLOT_W-1:0] s);
    return (s >= 5'd4) && (s <= 5'd19);
  endfunction

  function automatic ss_t pick_kind(input logic wr_ok, input logic rd_ok,
                                    input logic last_was_write);
    if (wr_ok && rd_ok) return last_was_write ? SS_READ : SS_WRITE;
    if (wr_ok)          return SS_WRITE;
    if (rd_ok)          return SS_READ;
    return SS_IDLE;
  endfunction

endpackage

// File: rtl/sdss_init.sv
module sdss_init import sdss_pkg::*; #(
  parameter int INIT_WAIT = 20000,
  parameter int TRP       = 2,
  parameter int TRFC      = 7,
  parameter int TMRD      = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy_o,
  output logic last_o,
  output cmd_t cmd_o,
  output logic a10_o,
  output logic mrs_o
);
  localparam int T_PRE  = INIT_WAIT;
  localparam int T_REF1 = T_PRE + TRP;
  localparam int T_REF2 = T_REF1 + TRFC;
  localparam int T_MRS  = T_REF2 + TRFC;
  localparam int T_RUN  = T_MRS + TMRD;
  localparam int CW     = $clog2(T_RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (cnt_q != CW'(T_RUN))  cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (cnt_q != CW'(T_RUN));
  assign last_o = (cnt_q == CW'(T_RUN - 1));

  always_comb begin
    cmd_o = CMD_NOP;
    a10_o = 1'b0;
    mrs_o = 1'b0;
    if (cnt_q == CW'(T_PRE)) begin
      cmd_o = CMD_PRE;
      a10_o = 1'b1;
    end else if (cnt_q == CW'(T_REF1) || cnt_q == CW'(T_REF2)) begin
      cmd_o = CMD_REF;
    end else if (cnt_q == CW'(T_MRS)) begin
      cmd_o = CMD_MRS;
      mrs_o = 1'b1;
    end
  end

  // R1: the mode load is the last command before the schedule takes over
  assert_mrs_before_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_o |=> busy_o);

endmodule

// File: rtl/sdss_sched.sv
module sdss_sched import sdss_pkg::*; #(
  parameter int FILL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [FILL_W-1:0]    wr_level_i,
  input  logic [FILL_W-1:0]    rd_free_i,
  output ss_t                  mode_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 ss_start_o,
  output logic                 ss_end_o
);
  localparam logic [FILL_W-1:0] NEED = FILL_W'(SS_WORDS);

  logic run_q, last_wr_q;
  logic [SLOT_W-1:0] slot_q;
  ss_t mode_q, next_kind;
  logic load;

  assign ss_end_o   = run_q && (slot_q == SLOT_W'(LAST_SLOT));
  assign ss_start_o = run_q && (slot_q == '0);
  assign load       = start_i || ss_end_o;
  assign next_kind  = pick_kind(wr_level_i >= NEED, rd_free_i >= NEED, last_wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      slot_q    <= '0;
      mode_q    <= SS_IDLE;
      last_wr_q <= 1'b0;
    end else if (load) begin
      run_q  <= 1'b1;
      slot_q <= '0;
      mode_q <= next_kind;
      if (next_kind != SS_IDLE) last_wr_q <= (next_kind == SS_WRITE);
    end else if (run_q) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign slot_o = slot_q;

  assert_wr_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_start_o && mode_q == SS_WRITE) |-> ($past(wr_level_i) >= NEED));

  assert_rd_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_start_o && mode_q == SS_READ) |-> ($past(rd_free_i) >= NEED));

  // R6: two eligible streams never give the same kind twice in a row
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_end_o && mode_q == SS_WRITE && wr_level_i >= NEED && rd_free_i >= NEED)
      |=> (mode_q == SS_READ));

endmodule

// File: rtl/sdss_addr.sv
module sdss_addr #(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W:0] col_sum;

  assign col_sum = {1'b0, col_o} + (COL_W+1)'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_o <= '0;
      col_o <= '0;
    end else if (adv_i) begin
      col_o <= col_sum[COL_W-1:0];
      if (col_sum[COL_W]) row_o <= row_o + 1'b1;
    end
  end

  // R7: the column stays aligned to a burst
  assert_col_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (col_o[1:0] == 2'b00));

endmodule

// File: rtl/sdram_stream_sched.sv
module sdram_stream_sched import sdss_pkg::*; #(
  parameter int DQ_W      = 16,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int FILL_W    = 8,
  parameter int INIT_WAIT = 20000,
  parameter int TRP       = 2,
  parameter int TRFC      = 7,
  parameter int TMRD      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] wr_level,
  input  logic [DQ_W-1:0]   wr_data,
  output logic              wr_pop,
  input  logic [FILL_W-1:0] rd_free,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(12'h022);

  logic init_busy, init_last, init_a10, init_mrs;
  cmd_t init_cmd;

  sdss_init #(.INIT_WAIT(INIT_WAIT), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD)) u_init (
    .clk(clk), .rst_n(rst_n), .busy_o(init_busy), .last_o(init_last),
    .cmd_o(init_cmd), .a10_o(init_a10), .mrs_o(init_mrs)
  );

  ss_t mode;
  logic [SLOT_W-1:0] slot;
  logic ss_start, ss_end;

  sdss_sched #(.FILL_W(FILL_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .start_i(init_last),
    .wr_level_i(wr_level), .rd_free_i(rd_free),
    .mode_o(mode), .slot_o(slot), .ss_start_o(ss_start), .ss_end_o(ss_end)
  );

  // index 0 = write stream, index 1 = read stream
  logic [ROW_W-1:0] row_s [2];
  logic [COL_W-1:0] col_s [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_ptr
    logic adv;
    assign adv = ss_end && (mode == ((gi == 0) ? SS_WRITE : SS_READ));
    sdss_addr #(.ROW_W(ROW_W), .COL_W(COL_W), .STEP(BURST)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .row_o(row_s[gi]), .col_o(col_s[gi])
    );
  end

  kind_t kind;
  logic [1:0] bank;
  logic sel_rd, active_ss;
  cmd_t cmd;

  assign kind      = slot_kind(slot);
  assign bank      = slot_bank(slot);
  assign sel_rd    = (mode == SS_READ);
  assign active_ss = !init_busy && (mode != SS_IDLE);

  always_comb begin
    cmd     = CMD_NOP;
    sd_ba   = 2'b00;
    sd_addr = '0;
    if (init_busy) begin
      cmd = init_cmd;
      if (init_mrs) sd_addr = MODE_WORD;
      if (init_a10) sd_addr[10] = 1'b1;
    end else if (active_ss) begin
      sd_ba = bank;
      case (kind)
        K_ACT: begin
          cmd     = CMD_ACT;
          sd_addr = ADDR_W'(row_s[sel_rd]);
        end
        K_RW: begin
          cmd     = sel_rd ? CMD_RD : CMD_WR;
          sd_addr = ADDR_W'(col_s[sel_rd]);
        end
        K_PRE:   cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cs_n   = 1'b0;
  assign wr_pop    = !init_busy && (mode == SS_WRITE) && write_beat(slot);
  assign sd_dq_oe  = wr_pop;
  assign sd_dq_out = wr_data;

  logic cap;
  assign cap = !init_busy && sel_rd && read_capture(slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= sd_dq_in;
    end
  end

  // ---- checking state: bank open map and pop counter ----
  logic [BANKS-1:0] open_q;
  logic [4:0] pop_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= '0;
      pop_cnt_q <= '0;
    end else begin
      if (cmd == CMD_ACT) open_q[sd_ba] <= 1'b1;
      if (cmd == CMD_PRE) begin
        if (sd_addr[10]) open_q <= '0;
        else             open_q[sd_ba] <= 1'b0;
      end
      pop_cnt_q <= ss_start ? 5'(wr_pop) : pop_cnt_q + 5'(wr_pop);
    end
  end

  assert_act_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> !open_q[sd_ba]);

  assert_rw_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> open_q[sd_ba]);

  assert_idle_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |-> (open_q == '0));

  assert_trcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |->
      ($past(cmd, 2) == CMD_ACT && $past(sd_ba, 2) == sd_ba));

  assert_no_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_busy |-> (cmd != CMD_REF && cmd != CMD_MRS));

  assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_end && mode == SS_WRITE) |-> (pop_cnt_q == 5'd16));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> (wr_level != '0));

endmodule

// File: tb/tb_sdram_stream_sched.sv
module tb_sdram_stream_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DQ_W = 16, ADDR_W = 11, ROW_W = 3, COL_W = 4, FILL_W = 8;
  localparam int INIT_WAIT = 10, TRP = 2, TRFC = 7, TMRD = 2;
  localparam int T_PRE = INIT_WAIT, T_REF1 = T_PRE + TRP, T_REF2 = T_REF1 + TRFC;
  localparam int T_MRS = T_REF2 + TRFC, T_RUN = T_MRS + TMRD;
  localparam int M_IDLE = 0, M_WR = 1, M_RD = 2;

  logic clk = 0, rst_n = 0;
  logic [FILL_W-1:0] wr_level = 0, rd_free = 0;
  logic [DQ_W-1:0] wr_data = 0, sd_dq_in = 0;
  logic wr_pop, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DQ_W-1:0] rd_data, sd_dq_out;
  logic [1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  sdram_stream_sched #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .FILL_W(FILL_W), .INIT_WAIT(INIT_WAIT), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_level(wr_level), .wr_data(wr_data), .wr_pop(wr_pop),
    .rd_free(rd_free), .rd_data(rd_data), .rd_valid(rd_valid), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // ---- scoreboard queues ----
  logic [DQ_W-1:0] wq[$];     // write FIFO contents
  logic [DQ_W-1:0] exp_q[$];  // expected read stream
  int word_seq = 0;

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DQ_W-1:0] w;
      w = DQ_W'(word_seq * 16'h9E37 + 16'h1234);
      word_seq++;
      wq.push_back(w);
      exp_q.push_back(w);
    end
  endtask

  always @(negedge clk) begin
    wr_level <= FILL_W'(wq.size());
    wr_data  <= (wq.size() != 0) ? wq[0] : '0;
  end

  // ---- memory model and monitor ----
  logic [DQ_W-1:0] mem [4*8*16];
  logic [ROW_W-1:0] open_row [4];
  logic [DQ_W-1:0] rsched [8];
  int wr_left = 0, wr_bank = 0, wr_col = 0;
  int cyc = 0, cur = M_IDLE, nxt = M_IDLE, last_w = 0;
  int ss_seen = 0, ws_seen = 0, rs_seen = 0;
  int wrow = 0, wcol = 0, rrow = 0, rcol = 0;

  function automatic int midx(input int b, input int r, input int c);
    return b * 128 + r * 16 + c;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic [2:0] cmd;
      int s, e_cmd, e_bank, e_addr, pop_exp, rv_exp;
      cmd = {sd_ras_n, sd_cas_n, sd_we_n};
      // memory model
      if (cmd == 3'b011) open_row[sd_ba] = ROW_W'(sd_addr);
      if (cmd == 3'b100) begin wr_left = 4; wr_bank = sd_ba; wr_col = int'(sd_addr[COL_W-1:0]); end
      if (wr_left > 0) begin
        if (sd_dq_oe) mem[midx(wr_bank, open_row[wr_bank], wr_col + 4 - wr_left)] = sd_dq_out;
        wr_left--;
      end
      if (cmd == 3'b101)
        for (int i = 0; i < 4; i++)
          rsched[(cyc + 1 + i) % 8] = mem[midx(sd_ba, open_row[sd_ba], int'(sd_addr[COL_W-1:0]) + i)];
      sd_dq_in <= rsched[cyc % 8];

      if (cyc < T_RUN) begin
        e_cmd = (cyc == T_PRE) ? 3'b010 : (cyc == T_REF1 || cyc == T_REF2) ? 3'b001 :
                (cyc == T_MRS) ? 3'b000 : 3'b111;
        chk(cmd == 3'(e_cmd), "R1 init command", cmd, e_cmd);
        if (cyc == T_PRE) chk(sd_addr[10] == 1'b1, "R1 precharge-all a10", sd_addr, 11'h400);
        if (cyc == T_MRS) chk(sd_addr == 11'h022 && sd_ba == 0, "R1 mode word", sd_addr, 11'h022);
        chk(!wr_pop && !rd_valid && !sd_dq_oe, "R1 quiet during init", {wr_pop, rd_valid}, 0);
      end else begin
        s = (cyc - T_RUN) % 21;
        if (s == 0) begin
          cur = nxt; ss_seen++;
          if (cur == M_WR) ws_seen++;
          if (cur == M_RD) rs_seen++;
        end
        e_cmd = 3'b111; e_bank = 0; e_addr = 0;
        if (cur != M_IDLE)
          for (int b = 0; b < 4; b++) begin
            if (s == 4*b)     begin e_cmd = 3'b011; e_bank = b; e_addr = (cur == M_WR) ? wrow : rrow; end
            if (s == 4*b + 2) begin e_cmd = (cur == M_WR) ? 3'b100 : 3'b101; e_bank = b;
                                    e_addr = (cur == M_WR) ? wcol : rcol; end
            if (s == 4*b + 7) begin e_cmd = 3'b010; e_bank = b; e_addr = 0; end
          end
        chk(cmd == 3'(e_cmd), (cur == M_IDLE) ? "R5 idle superstate NOP" : "R2 slot command", cmd, e_cmd);
        if (e_cmd != 3'b111 && cmd == 3'(e_cmd)) begin
          chk(sd_ba == 2'(e_bank), "R2 bank order", sd_ba, e_bank);
          chk(sd_addr == ADDR_W'(e_addr), "R7 row/column address", sd_addr, e_addr);
        end
        chk(cmd != 3'b001 && cmd != 3'b000, "R9 no refresh after init", cmd, 3'b111);
        pop_exp = (cur == M_WR && s >= 2 && s <= 17);
        chk(wr_pop == pop_exp[0] && sd_dq_oe == pop_exp[0], "R3 pop window", wr_pop, pop_exp);
        if (wr_pop) begin
          chk(wq.size() != 0 && sd_dq_out == wq[0], "R3 write data", sd_dq_out, wq.size() ? wq[0] : 0);
          if (wq.size() != 0) void'(wq.pop_front());
        end
        rv_exp = (cur == M_RD && s >= 5);
        chk(rd_valid == rv_exp[0], "R4 read valid window", rd_valid, rv_exp);
        if (rd_valid) begin
          chk(exp_q.size() != 0 && rd_data == exp_q[0], "R8 read stream order", rd_data,
              exp_q.size() ? exp_q[0] : 0);
          if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
        if (s == 20) begin
          if (cur == M_WR) begin wcol = (wcol + 4) % 16; if (wcol == 0) wrow = (wrow + 1) % 8; end
          if (cur == M_RD) begin rcol = (rcol + 4) % 16; if (rcol == 0) rrow = (rrow + 1) % 8; end
        end
      end
      // next superstate kind, from levels seen now (R5, R6)
      if (cyc == T_RUN - 1 || (cyc >= T_RUN && (cyc - T_RUN) % 21 == 20)) begin
        int wok, rok;
        wok = (wr_level >= 16); rok = (rd_free >= 16);
        if (wok && rok) nxt = last_w ? M_RD : M_WR;
        else if (wok)   nxt = M_WR;
        else if (rok)   nxt = M_RD;
        else            nxt = M_IDLE;
        if (nxt != M_IDLE) last_w = (nxt == M_WR);
      end
      cyc++;
    end
  end

  task automatic wait_until(input int which, input int n);
    while (((which == 0) ? ss_seen : (which == 1) ? ws_seen : rs_seen) < n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 4*8*16; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) rsched[i] = '0;
    for (int i = 0; i < 4; i++) open_row[i] = '0;
    repeat (3) @(negedge clk);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 reset NOP", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    chk(!wr_pop && !rd_valid && !sd_dq_oe && !sd_cs_n == 1'b1, "R1 reset outputs", {wr_pop, rd_valid, sd_dq_oe}, 0);
    push_words(15);              // one short of a write superstate (R5 boundary)
    rd_free = 15;                // one short of a read superstate (R5 boundary)
    @(negedge clk) rst_n = 1;
    wait_until(0, 2);
    chk(ws_seen == 0 && rs_seen == 0, "R5 levels of 15 stay idle", ws_seen + rs_seen, 0);
    push_words(1);               // exactly 16 -> write
    wait_until(1, 1);
    push_words(32);
    wait_until(1, 3);
    chk(rs_seen == 0, "R5 rd_free 15 blocks reads", rs_seen, 0);
    rd_free = 16;                // both eligible from here: alternation (R6)
    push_words(32);
    wait_until(2, 2);
    chk(ws_seen == 4, "R6 read then write alternate", ws_seen, 4);
    wait_until(2, 5);
    rd_free = 0;
    chk(ws_seen == 5, "R6 all writes served", ws_seen, 5);
    wait_until(0, ss_seen + 3);
    chk(exp_q.size() == 0, "R8 whole stream returned", exp_q.size(), 0);
    chk(wrow == 1 && wcol == 4, "R7 column wrap moved row", wrow * 16 + wcol, 20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule